// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is an SPI master that software drives through a small word-addressed register space. Bytes written to the transmit port queue up in a transmit FIFO. While the controller is switched on, the shift engine takes bytes from that FIFO one at a time and clocks each out MSB first. For every byte sent, the byte captured from the slave is placed in a receive FIFO, which software drains through the receive port. No start command exists: a byte leaves as soon as one is waiting and the engine is free.

Software chooses the active slave by writing a select field in the control word. The field is decoded by priority: the lowest zero bit picks the slave. The same control word holds the clock polarity, the clock phase and a three-bit divider exponent. A status word reports live FIFO conditions together with sticky event flags that software clears by writing ones. A mask register gates status bits onto a single interrupt line.

Top module: `spim_ctrl`

## Requirements
- R1: After reset the control word reads 0x00003C00, status reads 0x04, mask and enable read 0, ss_n is 3'b111, sclk is 0 and irq is 0.
- R2: Control bits 13:10 form the select field. If bit 10 is 0, ss_n[0] is low. Otherwise, if bit 11 is 0, ss_n[1] is low. Otherwise, if bit 12 is 0, ss_n[2] is low. Otherwise no select is low, so 4'b0111 and 4'b1111 both leave every line high.
- R3: At most one ss_n line is low at a time, and the selects follow the field whether or not the controller is enabled.
- R4: During a byte, every SCLK half period lasts 2^d reference clocks, where d is control bits 5:3. A full SCLK period is therefore (2 << d) clocks.
- R5: Control bit 1 (CPOL) is the SCLK level between bytes. With control bit 2 (CPHA) at 0, MISO is sampled on the leading edge of each SCLK cycle. With CPHA at 1, it is sampled on the trailing edge. MOSI carries the byte MSB first.
- R6: While enable bit 0 (offset 0x14) is set, bytes written to offset 0x1C are sent in write order. Each sent byte places the byte received with it into the receive FIFO, read in order at offset 0x20.
- R7: While enable bit 0 is clear, no byte begins shifting and SCLK stays at its idle level. Queued bytes go out once the bit is set.
- R8: Status (offset 0x04) bits: 2 = transmit FIFO not full, 3 = transmit FIFO full, 4 = receive FIFO not empty, 5 = receive FIFO full. These four track the FIFOs live.
- R9: Status bit 1 is set when a byte completes, bit 0 when a received byte is dropped, and bit 6 when a transmit write is dropped. Each stays set until a 1 is written to it at offset 0x04. Writing 1 to a live bit has no effect.
- R10: A write to offset 0x08 sets the mask bits given by its ones, and a write to 0x0C clears them. The mask reads back at 0x10. irq is high whenever a status bit and its mask bit are both 1.
- R11: Each FIFO holds 128 bytes. A transmit write to a full FIFO is dropped. A byte received while the receive FIFO is full is dropped, and the FIFO contents are unchanged.
- R12: Reading offset 0x20 while the receive FIFO is empty returns 0 and leaves the FIFO state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_sel |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| ss_n | output | 3 | Active-low slave selects |

## Verification
An engine edge counter or divider that drifts shows up as a wrong SCLK half-period length, or as SCLK not returning to its idle level. The reference model flags either at the next SCLK edge, or in the first idle cycle after the byte. A select decode fault appears on ss_n within the same cycle as the control write, and the bench compares ss_n on every clock. Corrupt FIFO pointers or counts appear as reordered or missing bytes on the receive port, or as wrong live status bits. These are caught when the byte is read back, or when status is read after a fill or drain.

// File: rtl/spim_pkg.sv
package spim_pkg;
   localparam int REG_AW = 6;

   localparam logic [REG_AW-1:0] OFS_CTRL = 6'h00;
   localparam logic [REG_AW-1:0] OFS_STAT = 6'h04;
   localparam logic [REG_AW-1:0] OFS_IEN  = 6'h08;
   localparam logic [REG_AW-1:0] OFS_IDIS = 6'h0C;
   localparam logic [REG_AW-1:0] OFS_MASK = 6'h10;
   localparam logic [REG_AW-1:0] OFS_EN   = 6'h14;
   localparam logic [REG_AW-1:0] OFS_TX   = 6'h1C;
   localparam logic [REG_AW-1:0] OFS_RX   = 6'h20;

   localparam int ST_W      = 7;
   localparam int ST_RXOVF  = 0;
   localparam int ST_DONE   = 1;
   localparam int ST_TXNF   = 2;
   localparam int ST_TXFULL = 3;
   localparam int ST_RXNE   = 4;
   localparam int ST_RXFULL = 5;
   localparam int ST_TXOVF  = 6;

   localparam int CB_CPOL   = 1;
   localparam int CB_CPHA   = 2;
   localparam int CB_DIV_LO = 3;
   localparam int CB_SEL_LO = 10;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 128
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int AW = $clog2(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;
   logic          do_push, do_pop;

   assign full    = (cnt == (AW+1)'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/spim_ssdec.sv
module spim_ssdec #(
   parameter int NUM_SS = 3
) (
   input  logic [NUM_SS-1:0] sel,
   output logic [NUM_SS-1:0] ss_n
);
   for (genvar i = 0; i < NUM_SS; i++) begin : g_line
      if (i == 0) begin : g_first
         assign ss_n[i] = sel[0];
      end else begin : g_rest
         assign ss_n[i] = !(!sel[i] && (&sel[i-1:0]));
      end
   end
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
   parameter int DW    = 8,
   parameter int DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DW-1:0]    tx_byte,
   input  logic [DIV_W-1:0] div,
   input  logic             cpol,
   input  logic             cpha,
   input  logic             miso,
   output logic             busy,
   output logic             done,
   output logic [DW-1:0]    rx_byte,
   output logic             sclk,
   output logic             mosi
);
   localparam int HC_W  = 1 << DIV_W;
   localparam int EDGES = 2 * DW;
   localparam int EC_W  = $clog2(EDGES);

   logic [HC_W-1:0]  cnt;
   logic [EC_W-1:0]  ecnt;
   logic [DIV_W-1:0] div_l;
   logic             cpol_l, cpha_l, tog;
   logic [DW-1:0]    tx_sh, rx_sh;
   logic             half_last, lead, samp_edge;

   assign half_last = (cnt == ((HC_W'(1) << div_l) - HC_W'(1)));
   assign lead      = !tog;
   assign samp_edge = cpha_l ? !lead : lead;
   assign sclk      = (busy ? cpol_l : cpol) ^ tog;
   assign mosi      = tx_sh[DW-1];
   assign rx_byte   = rx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         tog    <= 1'b0;
         cnt    <= '0;
         ecnt   <= '0;
         div_l  <= '0;
         cpol_l <= 1'b0;
         cpha_l <= 1'b0;
         tx_sh  <= '0;
         rx_sh  <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy   <= 1'b1;
               tx_sh  <= tx_byte;
               cnt    <= '0;
               ecnt   <= '0;
               div_l  <= div;
               cpol_l <= cpol;
               cpha_l <= cpha;
            end
         end else if (half_last) begin
            cnt  <= '0;
            tog  <= ~tog;
            ecnt <= ecnt + 1'b1;
            if (samp_edge) rx_sh <= {rx_sh[DW-2:0], miso};
            if (!samp_edge && (ecnt != '0)) tx_sh <= {tx_sh[DW-2:0], 1'b0};
            if (ecnt == EC_W'(EDGES-1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
   import spim_pkg::*;
#(
   parameter int DW         = 8,
   parameter int FIFO_DEPTH = 128,
   parameter int NUM_SS     = 3,
   parameter int DIV_W      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic [NUM_SS-1:0] ss_n
);
   localparam int          SEL_W      = NUM_SS + 1;
   localparam logic [31:0] SEL_ONES   = (32'd1 << SEL_W) - 32'd1;
   localparam logic [31:0] DIV_ONES   = (32'd1 << DIV_W) - 32'd1;
   localparam logic [31:0] CTRL_RST   = SEL_ONES << CB_SEL_LO;
   localparam logic [31:0] CTRL_WMASK = 32'h0000_C007 | (DIV_ONES << CB_DIV_LO) | CTRL_RST;

   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two, at least 2");
   end
   if (NUM_SS < 1 || NUM_SS > 3) begin : g_bad_ss
      $error("NUM_SS must be 1 to 3");
   end
   if (DW < 2 || DW > 32) begin : g_bad_dw
      $error("DW must be 2 to 32");
   end
   if (DIV_W < 1 || DIV_W > 7) begin : g_bad_div
      $error("DIV_W must be 1 to 7");
   end

   logic            wr_en, rd_en;
   logic [31:0]     ctrl_q;
   logic [ST_W-1:0] mask_q, status, w1c;
   logic            en_q;
   logic            rxovf_q, done_q, txovf_q;
   logic            ctrl_cpol, ctrl_cpha;
   logic [DIV_W-1:0] ctrl_div;

   logic            tx_push, tx_pop, tx_full, tx_empty;
   logic [DW-1:0]   tx_dout;
   logic            rx_push, rx_pop, rx_full, rx_empty;
   logic [DW-1:0]   rx_dout;
   logic            sh_busy, sh_done;
   logic [DW-1:0]   sh_rx;

   assign wr_en     = bus_sel && bus_wr;
   assign rd_en     = bus_sel && !bus_wr;
   assign ctrl_cpol = ctrl_q[CB_CPOL];
   assign ctrl_cpha = ctrl_q[CB_CPHA];
   assign ctrl_div  = ctrl_q[CB_DIV_LO +: DIV_W];

   assign tx_push = wr_en && (bus_addr == OFS_TX);
   assign tx_pop  = en_q && !sh_busy && !tx_empty;
   assign rx_push = sh_done;
   assign rx_pop  = rd_en && (bus_addr == OFS_RX);
   assign w1c     = (wr_en && bus_addr == OFS_STAT) ? bus_wdata[ST_W-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= CTRL_RST;
         mask_q  <= '0;
         en_q    <= 1'b0;
         rxovf_q <= 1'b0;
         done_q  <= 1'b0;
         txovf_q <= 1'b0;
      end else begin
         if (wr_en && bus_addr == OFS_CTRL) ctrl_q <= bus_wdata & CTRL_WMASK;
         if (wr_en && bus_addr == OFS_EN)   en_q   <= bus_wdata[0];
         if (wr_en && bus_addr == OFS_IEN)
            mask_q <= mask_q | bus_wdata[ST_W-1:0];
         else if (wr_en && bus_addr == OFS_IDIS)
            mask_q <= mask_q & ~bus_wdata[ST_W-1:0];
         rxovf_q <= (sh_done && rx_full) || (rxovf_q && !w1c[ST_RXOVF]);
         done_q  <= sh_done || (done_q && !w1c[ST_DONE]);
         txovf_q <= (tx_push && tx_full) || (txovf_q && !w1c[ST_TXOVF]);
      end
   end

   always_comb begin
      status            = '0;
      status[ST_RXOVF]  = rxovf_q;
      status[ST_DONE]   = done_q;
      status[ST_TXNF]   = !tx_full;
      status[ST_TXFULL] = tx_full;
      status[ST_RXNE]   = !rx_empty;
      status[ST_RXFULL] = rx_full;
      status[ST_TXOVF]  = txovf_q;
   end

   assign irq = |(status & mask_q);

   always_comb begin
      case (bus_addr)
         OFS_CTRL: bus_rdata = ctrl_q;
         OFS_STAT: bus_rdata = 32'(status);
         OFS_MASK: bus_rdata = 32'(mask_q);
         OFS_EN:   bus_rdata = {31'd0, en_q};
         OFS_RX:   bus_rdata = rx_empty ? 32'd0 : 32'(rx_dout);
         default:  bus_rdata = 32'd0;
      endcase
   end

   spim_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .din(bus_wdata[DW-1:0]),
      .pop(tx_pop), .dout(tx_dout), .full(tx_full), .empty(tx_empty));

   spim_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .din(sh_rx),
      .pop(rx_pop), .dout(rx_dout), .full(rx_full), .empty(rx_empty));

   spim_shift #(.DW(DW), .DIV_W(DIV_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(tx_pop), .tx_byte(tx_dout),
      .div(ctrl_div), .cpol(ctrl_cpol), .cpha(ctrl_cpha), .miso(miso),
      .busy(sh_busy), .done(sh_done), .rx_byte(sh_rx), .sclk(sclk), .mosi(mosi));

   spim_ssdec #(.NUM_SS(NUM_SS)) u_sel (
      .sel(ctrl_q[CB_SEL_LO +: NUM_SS]), .ss_n(ss_n));
endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk
   import spim_pkg::*;
#(
   parameter int NUM_SS = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [REG_AW-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              irq,
   input logic              sclk,
   input logic [NUM_SS-1:0] ss_n,
   input logic              sh_busy,
   input logic              en_q,
   input logic              ctrl_cpol,
   input logic              rx_full,
   input logic              rx_push,
   input logic              rx_pop
);
   assert_one_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~ss_n));

   assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !sh_busy |-> sclk == ctrl_cpol);

   assert_no_start_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !sh_busy) |=> !sh_busy);

   assert_mask_all_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == OFS_IDIS && bus_wdata[ST_W-1:0] == '1) |=> !irq);

   assert_rx_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && rx_push && !rx_pop) |=> rx_full);
endmodule

bind spim_ctrl spim_ctrl_chk #(.NUM_SS(NUM_SS)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq(irq), .sclk(sclk),
   .ss_n(ss_n), .sh_busy(sh_busy), .en_q(en_q), .ctrl_cpol(ctrl_cpol),
   .rx_full(rx_full), .rx_push(rx_push), .rx_pop(rx_pop));

// File: tb/spim_ctrl_test.sv
module spim_ctrl_test;
   import spim_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_sel, bus_wr;
   logic [5:0]  bus_addr;
   logic [31:0] bus_wdata, bus_rdata;
   logic        irq, sclk, mosi, miso;
   logic [2:0]  ss_n;

   always #4 clk = ~clk;

   spim_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n));

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [3:0] m_field = 4'hF;
   bit         m_cpol = 0, m_cpha = 0, active = 0;
   int         m_div = 0, since = 0, ecnt = 0, sl_n = 0;
   logic       prev_sclk = 1'b0;
   logic [7:0] sl_sh = 8'h00, acc = 8'h00;
   logic [7:0] sl_sent[$];
   logic [7:0] got[$];
   logic [7:0] txq[$];

   assign miso = sl_sh[7];

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [2:0] exp_ss(input logic [3:0] f);
      logic [2:0] r = 3'b111;
      for (int i = 0; i < 3; i++) begin
         if (f[i] == 1'b0) begin
            r[i] = 1'b0;
            break;
         end
      end
      return r;
   endfunction

   task automatic load_slave();
      sl_sh = 8'hA5 ^ 8'(sl_n * 29);
      sl_sent.push_back(sl_sh);
      sl_n++;
   endtask

   // reference model of the slave and of the selects, evaluated every clock
   always @(negedge clk) begin
      bit lead, samp;
      if (rst_n) chk("R3", "ss_n per cycle", {29'd0, ss_n}, {29'd0, exp_ss(m_field)});
      since++;
      if (active && sclk !== prev_sclk) begin
         lead = (sclk !== m_cpol);
         if (ecnt != 0) chk("R4", "half period", since, 1 << m_div);
         since = 0;
         samp = m_cpha ? !lead : lead;
         if (samp) acc = {acc[6:0], mosi};
         else if (m_cpha ? (ecnt != 0) : (ecnt != 15)) sl_sh = sl_sh << 1;
         if (ecnt == 15) begin
            got.push_back(acc);
            load_slave();
            ecnt = 0;
         end else begin
            ecnt++;
         end
      end
      prev_sclk = sclk;
   end

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 0; bus_wr = 0;
      if (a == OFS_CTRL) m_field = d[13:10];
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk); #1;
      bus_sel = 0;
   endtask

   task automatic setup(input bit cp, input bit ph, input int dv);
      active = 0;
      wr(OFS_EN, 0);
      wr(OFS_CTRL, 32'h3800 | (dv << 3) | (32'(ph) << 2) | (32'(cp) << 1) | 1);
      m_cpol = cp; m_cpha = ph; m_div = dv;
      @(negedge clk); #1;
      ecnt = 0; since = 0;
      got.delete(); sl_sent.delete(); txq.delete();
      load_slave();
      active = 1;
   endtask

   task automatic wait_bytes(input int n, input int dv);
      repeat (n * (16 * (1 << dv) + 4) + 20) @(posedge clk);
   endtask

   task automatic run_mode(input bit cp, input bit ph, input int dv, input int n);
      logic [31:0] d;
      logic [7:0]  b;
      setup(cp, ph, dv);
      for (int i = 0; i < n; i++) begin
         b = 8'(8'h3C + i * 71) ^ {6'd0, cp, ph};
         txq.push_back(b);
         wr(OFS_TX, 32'(b));
      end
      wr(OFS_EN, 1);
      wait_bytes(n, dv);
      @(negedge clk);
      chk("R5", "idle sclk level", 32'(sclk), 32'(cp));
      chk("R6", "bytes seen by slave", got.size(), n);
      for (int i = 0; i < n && i < got.size(); i++)
         chk("R5", "MOSI byte msb first", 32'(got[i]), 32'(txq[i]));
      for (int i = 0; i < n; i++) begin
         rd(OFS_RX, d);
         chk("R6", "received byte order", d, 32'(sl_sent[i]));
      end
      wr(OFS_STAT, 32'h7F);
   endtask

   initial begin
      #(200000 * 8);
      if (!finished) begin
         errors++;
         $display("FAIL R6 watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
      repeat (5) @(posedge clk);
      @(negedge clk); rst_n = 1;

      // R1 reset state
      rd(OFS_CTRL, d); chk("R1", "ctrl reset", d, 32'h3C00);
      rd(OFS_STAT, d); chk("R1", "status reset", d, 32'h04);
      rd(OFS_MASK, d); chk("R1", "mask reset", d, 0);
      rd(OFS_EN, d);   chk("R1", "enable reset", d, 0);
      @(negedge clk);
      chk("R1", "ss_n reset", 32'(ss_n), 32'h7);
      chk("R1", "sclk reset", 32'(sclk), 0);
      chk("R1", "irq reset", 32'(irq), 0);

      // R2 select decode, controller disabled (R3)
      wr(OFS_CTRL, 32'hE << 10); @(negedge clk); chk("R2", "field 1110", 32'(ss_n), 32'b110);
      wr(OFS_CTRL, 32'h1 << 10); @(negedge clk); chk("R2", "field 0001", 32'(ss_n), 32'b101);
      wr(OFS_CTRL, 32'h3 << 10); @(negedge clk); chk("R2", "field 0011", 32'(ss_n), 32'b011);
      wr(OFS_CTRL, 32'hB << 10); @(negedge clk); chk("R2", "field 1011", 32'(ss_n), 32'b011);
      wr(OFS_CTRL, 32'h7 << 10); @(negedge clk); chk("R2", "field 0111", 32'(ss_n), 32'b111);
      wr(OFS_CTRL, 32'h6 << 10); @(negedge clk); chk("R2", "field 0110", 32'(ss_n), 32'b110);
      wr(OFS_CTRL, 32'hF << 10); @(negedge clk); chk("R3", "field 1111", 32'(ss_n), 32'b111);

      // R4 R5 R6 all modes and several dividers
      run_mode(0, 0, 0, 3);
      run_mode(0, 1, 1, 3);
      run_mode(1, 0, 3, 3);
      run_mode(1, 1, 2, 3);
      run_mode(1, 0, 0, 4);

      // R12 empty receive read
      rd(OFS_RX, d);   chk("R12", "empty rx read", d, 0);
      rd(OFS_STAT, d); chk("R12", "status after empty read", d, 32'h04);

      // R7 disabled controller holds queued bytes
      setup(0, 0, 1);
      wr(OFS_TX, 32'h5A); wr(OFS_TX, 32'hC3);
      repeat (200) @(posedge clk);
      @(negedge clk);
      chk("R7", "no bytes while disabled", got.size(), 0);
      chk("R7", "sclk idle while disabled", 32'(sclk), 0);
      rd(OFS_STAT, d); chk("R7", "status while disabled", d, 32'h04);
      wr(OFS_EN, 1);
      wait_bytes(2, 1);
      chk("R7", "bytes after enable", got.size(), 2);
      if (got.size() == 2) chk("R7", "second byte", 32'(got[1]), 32'hC3);

      // R8 R9 R10 status, mask and irq (two rx bytes unread)
      rd(OFS_STAT, d); chk("R8", "status after transfer", d, 32'h16);
      @(negedge clk);  chk("R10", "irq masked", 32'(irq), 0);
      wr(OFS_IEN, 32'h10);
      rd(OFS_MASK, d); chk("R10", "mask after enable", d, 32'h10);
      @(negedge clk);  chk("R10", "irq from rx not empty", 32'(irq), 1);
      wr(OFS_IDIS, 32'h10);
      rd(OFS_MASK, d); chk("R10", "mask after disable", d, 0);
      @(negedge clk);  chk("R10", "irq after disable", 32'(irq), 0);
      wr(OFS_STAT, 32'h12);
      rd(OFS_STAT, d); chk("R9", "w1c done, live bit kept", d, 32'h14);
      wr(OFS_IEN, 32'h02);
      @(negedge clk);  chk("R9", "irq with cleared done", 32'(irq), 0);
      wr(OFS_IDIS, 32'h7F);
      rd(OFS_RX, d); rd(OFS_RX, d);

      // R11 FIFO depth and overflow handling
      setup(0, 0, 0);
      wr(OFS_STAT, 32'h7F);
      for (int i = 0; i < 129; i++) wr(OFS_TX, 32'(8'(i * 7 + 1)));
      rd(OFS_STAT, d); chk("R11", "tx full and dropped", d, 32'h48);
      wr(OFS_STAT, 32'h40);
      rd(OFS_STAT, d); chk("R9", "tx overflow cleared", d, 32'h08);
      wr(OFS_EN, 1);
      wait_bytes(128, 0);
      rd(OFS_STAT, d); chk("R11", "rx full", d, 32'h36);
      chk("R11", "bytes sent from full fifo", got.size(), 128);
      if (got.size() >= 128) chk("R11", "last stored tx byte", 32'(got[127]), 32'(8'(127 * 7 + 1)));
      wr(OFS_TX, 32'hE7);
      wait_bytes(1, 0);
      rd(OFS_STAT, d); chk("R11", "rx overflow flagged", d, 32'h37);
      if (got.size() >= 129) chk("R11", "byte after overflow", 32'(got[128]), 32'hE7);
      for (int i = 0; i < 128; i++) begin
         rd(OFS_RX, d);
         chk("R11", "rx content kept", d, 32'(sl_sent[i]));
      end
      rd(OFS_STAT, d); chk("R8", "status after drain", d, 32'h07);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule